// File: doc/BRIEF.md
# Display Identification Channel Slave Engine

This block lets a monitor tell a graphics host who it is. It reads an identification data structure from a byte-wide memory port and presents it on a two-wire clock/data pair in one of two ways. In the first way, the serial stream, the engine sends the 128-byte structure on its own without any host clock. Each rising edge of the vertical sync input moves the stream on by one bit. In the second way, the addressed mode, a host reaches the memory through a byte-oriented slave protocol of the I2C kind. The host can read and write through a paged address pointer.

After software sets the enable bit, the engine starts in the serial stream. Activity on SCL moves it into a guarded transition state, in which SDA is released and the slave listens for a device address. A valid address makes the addressed mode permanent. If no valid address arrives within 128 vsync edges, or before a programmable timeout, the engine returns to the serial stream. Software sets the page of the memory address, can write-protect the memory against the host, and gets an end-of-download flag with an interrupt enable.

Top module: `edid_ddc_engine`

## Requirements
- R1: While `hw_en` is low, `link_mode` is 0 (off), `sda_oe` is 0 and `mem_wr_en` is 0, whatever happens on vsync and SCL.
- R2: When `hw_en` rises, `link_mode` becomes 1 (serial stream), starting at byte 0, bit 7. Each byte is sent MSB first and then a ninth bit that is released high. A data bit of 0 is shown as `sda_oe`=1 (pull low). Each rising vsync edge moves the stream on by one bit.
- R3: In the serial stream the memory address is {`page_hi`, zero-extended byte index}. After byte 127 the stream goes back to byte 0.
- R4: A falling SCL edge in the serial stream moves the engine to `link_mode` 2 (transition). The engine then releases SDA and restarts both its vsync counter and its timer.
- R5: In the transition state, the 128th rising vsync edge without a valid device address returns the engine to `link_mode` 1.
- R6: In the transition state, `TIMEOUT_CYCLES` clock cycles without a valid device address return the engine to `link_mode` 1.
- R7: The engine acknowledges only the 7-bit device address 0x50 (bytes 0xA0 for write and 0xA1 for read). Once that address is received, `link_mode` becomes 3 and stays 3 until `hw_en` falls. Any other address gets no acknowledge and the mode does not change.
- R8: After a write address, the first byte is acknowledged and loaded into the low pointer. Each later byte is acknowledged and written to {`page_hi`, pointer}, and then the pointer increments.
- R9: With `wr_prot` high, data bytes are still acknowledged and the pointer still increments, but `mem_wr_en` stays low and the memory does not change.
- R10: A read returns the byte at {`page_hi`, pointer}, MSB first, and increments the pointer after each byte. A random read is done as a write of only the word address, followed by a repeated START and a read.
- R11: A NACK from the host after a read byte ends the transfer. SDA then stays released through any further SCL clocks until the next START.
- R12: A STOP that closes a session with at least one data byte written sets `eod_flag`. `eod_irq` is `eod_flag` AND `eod_ie`. `eod_clr` clears the flag. A write of only the word address does not set it.
- R13: When `hw_en` falls, the engine returns to `link_mode` 0. When `hw_en` is set again, the serial stream restarts at byte 0, bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_en | input | 1 | Software enable for the engine |
| wr_prot | input | 1 | Blocks memory writes from the host side |
| eod_ie | input | 1 | End-of-download interrupt enable |
| eod_clr | input | 1 | Clears the end-of-download flag |
| page_hi | input | PAGE_W | Selects the 256-byte block of the memory address |
| vsync_in | input | 1 | Vertical sync; its rising edges clock the serial stream |
| scl_in | input | 1 | Level of the serial clock line |
| sda_in | input | 1 | Level of the serial data line |
| sda_oe | output | 1 | When 1, pulls the open-drain data line low |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_rd_data | input | 8 | Read data for mem_addr, same cycle |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_data | output | 8 | Memory write data |
| eod_flag | output | 1 | End-of-download flag |
| eod_irq | output | 1 | End-of-download interrupt request |
| link_mode | output | 2 | 0 off, 1 serial stream, 2 transition, 3 addressed |

## Verification
On every cycle, the assertions check the rules of the mode state machine: the engine stays quiet while off, enters the addressed mode only from the transition state and then keeps it, and leaves the transition state on the 128th vsync edge. They also check that the slave only starts pulling SDA low while SCL is low, that the serial bit position stays in range and wraps at byte 127, and that the end-of-download flag is set only by a STOP. Other behaviour can only be shown by the bench scenarios. These cover the bit order and the released ninth bit of the serial stream, the memory contents after paged and protected writes, the data returned by current-address and random reads, the silence of SDA after a host NACK, and the timeout exit.

// File: rtl/edid_pkg.sv
package edid_pkg;

    typedef enum logic [1:0] {
        LM_OFF   = 2'd0,
        LM_DDC1  = 2'd1,
        LM_TRANS = 2'd2,
        LM_DDC2  = 2'd3
    } link_mode_e;

    typedef enum logic [2:0] {
        SL_IDLE,
        SL_RX,
        SL_ACK,
        SL_TX,
        SL_TXACK
    } slave_st_e;

    typedef enum logic [1:0] {
        RX_DEV,
        RX_WADR,
        RX_DATA
    } rx_kind_e;

    localparam logic [6:0] DEV_ADDR7 = 7'h50;

endpackage

// File: rtl/ddc_pin_sync.sv
module ddc_pin_sync #(
    parameter int              N    = 3,
    parameter logic [N-1:0]    IDLE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] lvl,
    output logic [N-1:0] prv
);
    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] sync;
        logic [N-1:0] last;
    } pipe_t;

    pipe_t p_d, p_q;

    always_comb begin
        p_d      = p_q;
        p_d.meta = d;
        p_d.sync = p_q.meta;
        p_d.last = p_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '{meta: IDLE, sync: IDLE, last: IDLE};
        else        p_q <= p_d;
    end

    assign lvl = p_q.sync;
    assign prv = p_q.last;

endmodule

// File: rtl/ddc1_serializer.sv
module ddc1_serializer #(
    parameter int BYTES = 128,
    localparam int IW   = $clog2(BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          advance,
    input  logic [7:0]    byte_in,
    output logic [IW-1:0] idx,
    output logic          bit_out,
    output logic          null_slot
);
    typedef struct packed {
        logic [3:0]    bitpos;
        logic [IW-1:0] idx;
    } ser_t;

    ser_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clear) begin
            s_d = '0;
        end else if (advance) begin
            if (s_q.bitpos == 4'd8) begin
                s_d.bitpos = 4'd0;
                s_d.idx    = (s_q.idx == IW'(BYTES - 1)) ? '0 : s_q.idx + 1'b1;
            end else begin
                s_d.bitpos = s_q.bitpos + 4'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign idx       = s_q.idx;
    assign null_slot = (s_q.bitpos == 4'd8);
    assign bit_out   = null_slot ? 1'b1 : byte_in[3'd7 - s_q.bitpos[2:0]];

    // R2: bit position never leaves the nine-slot frame
    a_r2_bitpos_range: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.bitpos <= 4'd8);

    // R3: last slot of the last byte wraps to byte 0
    a_r3_stream_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && advance && s_q.bitpos == 4'd8 && s_q.idx == IW'(BYTES - 1))
        |=> (s_q.idx == '0 && s_q.bitpos == 4'd0));

endmodule

// File: rtl/ddc_i2c_slave.sv
module ddc_i2c_slave
    import edid_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       scl_lvl,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       sda_lvl,
    input  logic       sda_rise,
    input  logic       sda_fall,
    input  logic [7:0] rd_byte,
    output logic       sda_drive,
    output logic       dev_match,
    output logic       lo_load,
    output logic       wr_stb,
    output logic       rd_next,
    output logic       stop_stb,
    output logic [7:0] rx_byte
);
    typedef struct packed {
        slave_st_e  st;
        rx_kind_e   kind;
        logic [3:0] bitcnt;
        logic [7:0] sh;
        logic       rw;
        logic       drv;
        logic       mack;
    } slv_t;

    localparam slv_t SLV_RST = '{st: SL_IDLE, kind: RX_DEV, bitcnt: 4'd0,
                                 sh: 8'h00, rw: 1'b0, drv: 1'b0, mack: 1'b0};

    slv_t s_d, s_q;
    logic start_c, stop_c;

    assign start_c = sda_fall & scl_lvl;
    assign stop_c  = sda_rise & scl_lvl;

    always_comb begin
        s_d       = s_q;
        dev_match = 1'b0;
        lo_load   = 1'b0;
        wr_stb    = 1'b0;
        rd_next   = 1'b0;
        stop_stb  = 1'b0;
        if (!enable) begin
            s_d = SLV_RST;
        end else if (start_c) begin
            s_d.st     = SL_RX;
            s_d.kind   = RX_DEV;
            s_d.bitcnt = 4'd0;
            s_d.drv    = 1'b0;
        end else if (stop_c) begin
            s_d.st   = SL_IDLE;
            s_d.drv  = 1'b0;
            stop_stb = 1'b1;
        end else begin
            case (s_q.st)
                SL_RX: begin
                    if (scl_rise && s_q.bitcnt < 4'd8) begin
                        s_d.sh     = {s_q.sh[6:0], sda_lvl};
                        s_d.bitcnt = s_q.bitcnt + 4'd1;
                    end
                    if (scl_fall && s_q.bitcnt == 4'd8) begin
                        case (s_q.kind)
                            RX_DEV: begin
                                if (s_q.sh[7:1] == DEV_ADDR7) begin
                                    dev_match = 1'b1;
                                    s_d.rw    = s_q.sh[0];
                                    s_d.st    = SL_ACK;
                                    s_d.drv   = 1'b1;
                                end else begin
                                    s_d.st = SL_IDLE;
                                end
                            end
                            RX_WADR: begin
                                lo_load = 1'b1;
                                s_d.st  = SL_ACK;
                                s_d.drv = 1'b1;
                            end
                            default: begin
                                wr_stb  = 1'b1;
                                s_d.st  = SL_ACK;
                                s_d.drv = 1'b1;
                            end
                        endcase
                    end
                end
                SL_ACK: begin
                    if (scl_fall) begin
                        if (s_q.kind == RX_DEV && s_q.rw) begin
                            s_d.st     = SL_TX;
                            s_d.drv    = ~rd_byte[7];
                            s_d.sh     = {rd_byte[6:0], 1'b0};
                            s_d.bitcnt = 4'd1;
                        end else begin
                            s_d.st     = SL_RX;
                            s_d.drv    = 1'b0;
                            s_d.bitcnt = 4'd0;
                            s_d.kind   = (s_q.kind == RX_DEV) ? RX_WADR : RX_DATA;
                        end
                    end
                end
                SL_TX: begin
                    if (scl_fall) begin
                        if (s_q.bitcnt == 4'd8) begin
                            s_d.drv = 1'b0;
                            s_d.st  = SL_TXACK;
                            rd_next = 1'b1;
                        end else begin
                            s_d.drv    = ~s_q.sh[7];
                            s_d.sh     = {s_q.sh[6:0], 1'b0};
                            s_d.bitcnt = s_q.bitcnt + 4'd1;
                        end
                    end
                end
                SL_TXACK: begin
                    if (scl_rise) s_d.mack = ~sda_lvl;
                    if (scl_fall) begin
                        if (s_q.mack) begin
                            s_d.st     = SL_TX;
                            s_d.drv    = ~rd_byte[7];
                            s_d.sh     = {rd_byte[6:0], 1'b0};
                            s_d.bitcnt = 4'd1;
                        end else begin
                            s_d.st = SL_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= SLV_RST;
        else        s_q <= s_d;
    end

    assign sda_drive = s_q.drv;
    assign rx_byte   = s_q.sh;

    // R7: the slave starts pulling SDA low only while SCL is low
    a_r7_drive_when_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.drv) |-> !scl_lvl);

    // R11: an idle slave keeps SDA released
    a_r11_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SL_IDLE) |-> !s_q.drv);

endmodule

// File: rtl/edid_ddc_engine.sv
module edid_ddc_engine
    import edid_pkg::*;
#(
    parameter int ADDR_W         = 16,
    parameter int PAGE_W         = 8,
    parameter int DDC1_BYTES     = 128,
    parameter int TIMEOUT_CYCLES = 200_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_en,
    input  logic              wr_prot,
    input  logic              eod_ie,
    input  logic              eod_clr,
    input  logic [PAGE_W-1:0] page_hi,
    input  logic              vsync_in,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rd_data,
    output logic              mem_wr_en,
    output logic [7:0]        mem_wr_data,
    output logic              eod_flag,
    output logic              eod_irq,
    output logic [1:0]        link_mode
);
    localparam int LO_W = ADDR_W - PAGE_W;
    localparam int IW   = $clog2(DDC1_BYTES);
    localparam int VW   = $clog2(DDC1_BYTES);
    localparam int TW   = $clog2(TIMEOUT_CYCLES);

    typedef struct packed {
        link_mode_e  mode;
        logic [VW-1:0] vcnt;
        logic [TW-1:0] tmr;
        logic [LO_W-1:0] ptr;
        logic        sess;
        logic        eod;
    } eng_t;

    eng_t st_d, st_q;

    logic [2:0] pin_lvl, pin_prv;
    logic vs_edge, scl_rise, scl_fall, sda_rise, sda_fall;
    logic ser_clear, ser_adv, ser_bit, ser_null;
    logic [IW-1:0] ser_idx;
    logic slave_en, slave_drv, dev_match, lo_load, wr_stb, rd_next, stop_stb;
    logic [7:0] rx_byte;
    logic eod_set;

    ddc_pin_sync #(.N(3), .IDLE(3'b011)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d   ({vsync_in, scl_in, sda_in}),
        .lvl (pin_lvl),
        .prv (pin_prv)
    );

    assign vs_edge  =  pin_lvl[2] & ~pin_prv[2];
    assign scl_rise =  pin_lvl[1] & ~pin_prv[1];
    assign scl_fall = ~pin_lvl[1] &  pin_prv[1];
    assign sda_rise =  pin_lvl[0] & ~pin_prv[0];
    assign sda_fall = ~pin_lvl[0] &  pin_prv[0];

    assign ser_clear = (st_q.mode == LM_OFF);
    assign ser_adv   = (st_q.mode == LM_DDC1) & vs_edge;
    assign slave_en  = (st_q.mode == LM_TRANS) || (st_q.mode == LM_DDC2);

    ddc1_serializer #(.BYTES(DDC1_BYTES)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (ser_clear),
        .advance   (ser_adv),
        .byte_in   (mem_rd_data),
        .idx       (ser_idx),
        .bit_out   (ser_bit),
        .null_slot (ser_null)
    );

    ddc_i2c_slave u_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (slave_en),
        .scl_lvl   (pin_lvl[1]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_lvl   (pin_lvl[0]),
        .sda_rise  (sda_rise),
        .sda_fall  (sda_fall),
        .rd_byte   (mem_rd_data),
        .sda_drive (slave_drv),
        .dev_match (dev_match),
        .lo_load   (lo_load),
        .wr_stb    (wr_stb),
        .rd_next   (rd_next),
        .stop_stb  (stop_stb),
        .rx_byte   (rx_byte)
    );

    always_comb begin
        st_d    = st_q;
        eod_set = 1'b0;
        case (st_q.mode)
            LM_OFF: begin
                if (hw_en) st_d.mode = LM_DDC1;
            end
            LM_DDC1: begin
                if (scl_fall) begin
                    st_d.mode = LM_TRANS;
                    st_d.vcnt = '0;
                    st_d.tmr  = '0;
                end
            end
            LM_TRANS: begin
                if (dev_match) begin
                    st_d.mode = LM_DDC2;
                end else if (vs_edge && st_q.vcnt == VW'(DDC1_BYTES - 1)) begin
                    st_d.mode = LM_DDC1;
                end else if (st_q.tmr == TW'(TIMEOUT_CYCLES - 1)) begin
                    st_d.mode = LM_DDC1;
                end else begin
                    st_d.tmr = st_q.tmr + 1'b1;
                    if (vs_edge) st_d.vcnt = st_q.vcnt + 1'b1;
                end
            end
            default: ;
        endcase

        if (lo_load)               st_d.ptr = rx_byte;
        else if (wr_stb | rd_next) st_d.ptr = st_q.ptr + 1'b1;

        if (wr_stb) st_d.sess = 1'b1;
        if (stop_stb) begin
            eod_set   = st_q.sess;
            st_d.sess = 1'b0;
        end
        st_d.eod = (st_q.eod & ~eod_clr) | eod_set;

        if (!hw_en) begin
            st_d.mode = LM_OFF;
            st_d.sess = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: LM_OFF, vcnt: '0, tmr: '0, ptr: '0, sess: 1'b0, eod: 1'b0};
        else        st_q <= st_d;
    end

    assign mem_addr    = (st_q.mode == LM_DDC1) ? {page_hi, LO_W'(ser_idx)}
                                                : {page_hi, st_q.ptr};
    assign mem_wr_en   = wr_stb & ~wr_prot & (st_q.mode == LM_DDC2);
    assign mem_wr_data = rx_byte;
    assign sda_oe      = ((st_q.mode == LM_DDC1) & ~ser_bit) | (slave_en & slave_drv);
    assign eod_flag    = st_q.eod;
    assign eod_irq     = st_q.eod & eod_ie;
    assign link_mode   = st_q.mode;

    // R1: an engine that is off never touches the bus or the memory
    a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == LM_OFF) |-> (!sda_oe && !mem_wr_en));

    // R2: the ninth slot of the serial stream leaves SDA released
    a_r2_null_released: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == LM_DDC1 && ser_null) |-> !sda_oe);

    // R7: addressed mode is reached only through the transition state
    a_r7_ddc2_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == LM_DDC2) |-> ($past(st_q.mode) == LM_TRANS || $past(st_q.mode) == LM_DDC2));

    // R7: addressed mode holds while enabled
    a_r7_ddc2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == LM_DDC2 && hw_en) |=> (st_q.mode == LM_DDC2));

    // R5: 128th vsync edge in transition falls back to the serial stream
    a_r5_vsync_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == LM_TRANS && hw_en && !dev_match && vs_edge &&
         st_q.vcnt == VW'(DDC1_BYTES - 1)) |=> (st_q.mode == LM_DDC1));

    // R12: the end-of-download flag rises only on a STOP
    a_r12_eod_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.eod) |-> $past(stop_stb));

endmodule

// File: tb/tb_edid_ddc_engine.sv
module tb_edid_ddc_engine;
    localparam int TMO = 2000;
    localparam int H   = 10;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic hw_en = 1'b0, wr_prot = 1'b0, eod_ie = 1'b0, eod_clr = 1'b0;
    logic [7:0] page_hi = 8'h00;
    logic vsync = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe, mem_wr_en, eod_flag, eod_irq;
    logic [15:0] mem_addr;
    logic [7:0] mem_rd_data, mem_wr_data;
    logic [1:0] link_mode;
    wire sda_line = sda_m & ~sda_oe;

    logic [7:0] mem [0:511];

    edid_ddc_engine #(.TIMEOUT_CYCLES(TMO)) dut (
        .clk (clk), .rst_n (rst_n), .hw_en (hw_en), .wr_prot (wr_prot),
        .eod_ie (eod_ie), .eod_clr (eod_clr), .page_hi (page_hi),
        .vsync_in (vsync), .scl_in (scl_m), .sda_in (sda_line), .sda_oe (sda_oe),
        .mem_addr (mem_addr), .mem_rd_data (mem_rd_data), .mem_wr_en (mem_wr_en),
        .mem_wr_data (mem_wr_data), .eod_flag (eod_flag), .eod_irq (eod_irq),
        .link_mode (link_mode)
    );

    function automatic logic [7:0] init_val(int i);
        return 8'((i * 29 + 7) & 255);
    endfunction

    initial for (int i = 0; i < 512; i++) mem[i] = init_val(i);
    always @(posedge clk) if (mem_wr_en) mem[mem_addr[8:0]] <= mem_wr_data;
    assign mem_rd_data = mem[mem_addr[8:0]];

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic check_eq(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic vs_pulse();
        vsync = 1'b1; wait_n(5); vsync = 1'b0; wait_n(5);
    endtask

    task automatic wake_bus();
        scl_m = 1'b0; wait_n(H); scl_m = 1'b1; wait_n(H);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wait_n(H); scl_m = 1'b1; wait_n(H);
        sda_m = 1'b0; wait_n(H); scl_m = 1'b0; wait_n(H);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wait_n(H); scl_m = 1'b1; wait_n(H); sda_m = 1'b1; wait_n(H);
    endtask

    task automatic i2c_wr(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_n(H); scl_m = 1'b1; wait_n(H); scl_m = 1'b0; wait_n(H);
        end
        sda_m = 1'b1; wait_n(H); scl_m = 1'b1; wait_n(H);
        ack = !sda_line;
        scl_m = 1'b0; wait_n(H);
    endtask

    task automatic i2c_rd(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            scl_m = 1'b1; wait_n(H); b = {b[6:0], sda_line}; scl_m = 1'b0; wait_n(H);
        end
        sda_m = !give_ack; wait_n(H); scl_m = 1'b1; wait_n(H); scl_m = 1'b0; wait_n(H);
        sda_m = 1'b1;
    endtask

    function automatic int exp_oe(int addr, int slot);
        if (slot == 8) return 0;
        return init_val(addr)[7 - slot] ? 0 : 1;
    endfunction

    task automatic t_reset_state();
        check_eq("R1 mode after reset", link_mode, 0);
        check_eq("R1 sda after reset", sda_oe, 0);
        wake_bus(); vs_pulse(); vs_pulse();
        check_eq("R1 mode while disabled", link_mode, 0);
        check_eq("R1 sda while disabled", {sda_oe, mem_wr_en, eod_flag}, 0);
    endtask

    task automatic t_ddc1_stream();
        hw_en = 1'b1; wait_n(4);
        check_eq("R2 mode serial", link_mode, 1);
        for (int p = 0; p < 18; p++) begin
            check_eq($sformatf("R2 stream slot %0d", p), sda_oe, exp_oe(p / 9, p % 9));
            vs_pulse();
        end
    endtask

    task automatic t_ddc1_wrap();
        repeat (127 * 9 - 18) vs_pulse();
        check_eq("R3 byte 127 msb", sda_oe, exp_oe(127, 0));
        repeat (9) vs_pulse();
        check_eq("R3 wrap to byte 0", sda_oe, exp_oe(0, 0));
        vs_pulse();
        check_eq("R3 wrap byte 0 bit 6", sda_oe, exp_oe(0, 1));
    endtask

    task automatic t_trans_vsync();
        wake_bus();
        check_eq("R4 transition entered", link_mode, 2);
        check_eq("R4 sda released", sda_oe, 0);
        repeat (127) vs_pulse();
        check_eq("R5 still transition", link_mode, 2);
        vs_pulse();
        check_eq("R5 back to serial", link_mode, 1);
    endtask

    task automatic t_trans_timeout();
        wake_bus();
        wait_n(TMO - 100);
        check_eq("R6 before timeout", link_mode, 2);
        wait_n(200);
        check_eq("R6 after timeout", link_mode, 1);
    endtask

    task automatic t_addr_filter_and_write();
        bit ack;
        page_hi = 8'h01; eod_ie = 1'b1;
        wake_bus();
        i2c_start(); i2c_wr(8'hA4, ack);
        check_eq("R7 foreign address nack", ack, 0);
        check_eq("R7 mode unchanged", link_mode, 2);
        i2c_stop();
        i2c_start(); i2c_wr(8'hA0, ack);
        check_eq("R7 device address ack", ack, 1);
        check_eq("R7 addressed mode", link_mode, 3);
        i2c_wr(8'h10, ack);
        check_eq("R8 word address ack", ack, 1);
        i2c_wr(8'h5A, ack);
        check_eq("R8 data ack", ack, 1);
        i2c_wr(8'hC3, ack);
        check_eq("R12 no flag before stop", eod_flag, 0);
        i2c_stop(); wait_n(3);
        check_eq("R8 byte at page 1 offset 10", mem[9'h110], 8'h5A);
        check_eq("R8 byte at page 1 offset 11", mem[9'h111], 8'hC3);
        check_eq("R8 neighbour untouched", mem[9'h112], init_val(9'h112));
        check_eq("R12 flag after stop", {eod_flag, eod_irq}, 2'b11);
        eod_ie = 1'b0; wait_n(1);
        check_eq("R12 irq masked", {eod_flag, eod_irq}, 2'b10);
        eod_clr = 1'b1; wait_n(1); eod_clr = 1'b0; wait_n(1);
        check_eq("R12 flag cleared", eod_flag, 0);
    endtask

    task automatic t_write_protect();
        bit ack;
        logic [7:0] b;
        wr_prot = 1'b1;
        i2c_start(); i2c_wr(8'hA0, ack); i2c_wr(8'h20, ack); i2c_wr(8'h77, ack);
        check_eq("R9 protected data still acked", ack, 1);
        i2c_stop(); wait_n(3);
        check_eq("R9 memory unchanged", mem[9'h120], init_val(9'h120));
        wr_prot = 1'b0;
        i2c_start(); i2c_wr(8'hA1, ack); i2c_rd(1'b0, b); i2c_stop();
        check_eq("R9 pointer advanced past blocked write", b, init_val(9'h121));
        eod_clr = 1'b1; wait_n(1); eod_clr = 1'b0; wait_n(1);
    endtask

    task automatic t_random_read_nack();
        bit ack;
        logic [7:0] b;
        bit quiet;
        i2c_start(); i2c_wr(8'hA0, ack); i2c_wr(8'h40, ack);
        i2c_start(); i2c_wr(8'hA1, ack);
        i2c_rd(1'b1, b);
        check_eq("R10 random read first byte", b, init_val(9'h140));
        i2c_rd(1'b0, b);
        check_eq("R10 random read second byte", b, init_val(9'h141));
        quiet = 1;
        for (int i = 0; i < 9; i++) begin
            scl_m = 1'b1; wait_n(H);
            if (!sda_line) quiet = 0;
            scl_m = 1'b0; wait_n(H);
        end
        check_eq("R11 sda silent after nack", quiet, 1);
        i2c_stop(); wait_n(3);
        check_eq("R12 dummy write sets no flag", eod_flag, 0);
        i2c_start(); i2c_wr(8'hA1, ack); i2c_rd(1'b0, b); i2c_stop();
        check_eq("R10 current address read", b, init_val(9'h142));
    endtask

    task automatic t_sticky_and_disable();
        repeat (200) vs_pulse();
        check_eq("R7 addressed mode kept", link_mode, 3);
        hw_en = 1'b0; wait_n(4);
        check_eq("R13 off after disable", link_mode, 0);
        check_eq("R13 sda released", sda_oe, 0);
        hw_en = 1'b1; wait_n(4);
        check_eq("R13 serial after re-enable", link_mode, 1);
        check_eq("R13 restart at byte 0 of page", sda_oe, exp_oe(256, 0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(3);
        t_reset_state();
        t_ddc1_stream();
        t_ddc1_wrap();
        t_trans_vsync();
        t_trans_timeout();
        t_addr_filter_and_write();
        t_write_protect();
        t_random_read_nack();
        t_sticky_and_disable();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule